// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block limits the peak current of a motor winding. It takes a current-limit comparator flag that has already been synchronized to its clock. When that flag is seen while the block is armed, the block pulls its PWM output low for a fixed off interval. During that interval the winding current recirculates through the low-side switches, so the sense comparator cannot see it. The block then releases the PWM output. The on time is not fixed. It lasts however long the current takes to climb back to the threshold. This makes the block a retriggerable one-shot, not a fixed-frequency PWM generator.

The off interval is picked by a 2-bit select, from four durations given in microseconds. Each duration is turned into clock cycles through a clock-frequency parameter. A select of zero gives the 30 µs value, so tying the select low gives that duration. After every off interval there is a blanking window whose length is set at an input. During that window the PWM output stays high and the comparator flag is ignored, so a switching spike cannot retrigger the chopper. The PWM level also gates a bundle of commutation enables: while PWM is low, every gated line is forced off.

Top module: `chop_const_toff`

## Requirements
- R1: After reset the PWM output is high, the block is armed, and `pat_o` equals `pat_i`.
- R2: If `oc_i` is high at a rising edge while the block is armed, `pwm_o` is low from that edge on for exactly N consecutive cycles, where N is the cycle count of the selected off time.
- R3: The `toff_sel_i` encoding is 2'b00 = 30 µs, 2'b01 = 20 µs, 2'b10 = 45 µs, 2'b11 = 70 µs. N = microseconds × (CLK_HZ / 1,000,000).
- R4: The select value is captured when an off interval starts. Changing `toff_sel_i` during the interval does not change its length.
- R5: An `oc_i` pulse during an off interval is ignored. It neither extends nor restarts the interval.
- R6: When an off interval ends, `pwm_o` is high for B = `blank_len_i` cycles of blanking. An `oc_i` pulse that ends before the last blanking cycle starts no new off interval.
- R7: If `oc_i` stays high, a new off interval starts right after blanking. The high gap between two off intervals is max(B, 1) cycles.
- R8: While `oc_i` stays low, `pwm_o` stays high with no limit on duration.
- R9: Each bit of `pat_o` equals the matching bit of `pat_i` while `pwm_o` is high. Every bit is 0 while `pwm_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| oc_i | input | 1 | Synchronized overcurrent flag, high when the sensed current is above the limit |
| toff_sel_i | input | 2 | Off-time select (see R3) |
| blank_len_i | input | BLANK_W | Blanking length in cycles after each off interval |
| pat_i | input | NPH | Commutation enable pattern to be chopped |
| pwm_o | output | 1 | Chopper output, high = conduct, low = off interval |
| pat_o | output | NPH | Commutation pattern gated by `pwm_o` |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz, so one cycle equals one microsecond and the four off times become 20, 30, 45 and 70 cycles. At that size, every select code can be swept against blanking lengths of 0, 1, 3 and 7 in a few thousand cycles. The sweep covers the case where B = 0 folds into a one-cycle gap. The expected lengths come from the microsecond table and the max(B, 1) rule. The bench also runs the full eight-value pattern space of a three-phase gate with PWM high and with PWM low.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_OFF   = 2'd1,
    ST_BLANK = 2'd2
  } chop_state_e;

  // Off duration in microseconds for a select code (code 0 is the default 30 us).
  function automatic int unsigned toff_us(input logic [1:0] sel);
    case (sel)
      2'd0:    return 30;
      2'd1:    return 20;
      2'd2:    return 45;
      default: return 70;
    endcase
  endfunction

  // Off duration in clock cycles.
  function automatic int unsigned toff_cycles(input logic [1:0] sel,
                                              input int unsigned cyc_per_us);
    return toff_us(sel) * cyc_per_us;
  endfunction

endpackage

// File: rtl/chop_offtime_sel.sv
module chop_offtime_sel #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CYC_PER_US = 250
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] len_m1_o
);
  localparam int unsigned NSEL = 4;

  logic [CNT_W-1:0] tbl [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_tbl
    assign tbl[g] = CNT_W'(chop_pkg::toff_cycles(2'(g), CYC_PER_US) - 1);
  end

  assign len_m1_o = tbl[sel_i];

endmodule

// File: rtl/chop_down_timer.sv
module chop_down_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/chop_pattern_gate.sv
module chop_pattern_gate #(
  parameter int unsigned NPH = 3
) (
  input  logic           pwm_i,
  input  logic [NPH-1:0] pat_i,
  output logic [NPH-1:0] pat_o
);
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign pat_o[p] = pat_i[p] & pwm_i;
  end
endmodule

// File: rtl/chop_const_toff.sv
module chop_const_toff #(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned BLANK_W = 8,
  parameter int unsigned NPH     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               oc_i,
  input  logic [1:0]         toff_sel_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  input  logic [NPH-1:0]     pat_i,
  output logic               pwm_o,
  output logic [NPH-1:0]     pat_o
);
  import chop_pkg::*;

  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned MAX_OFF    = 70 * CYC_PER_US;
  localparam int unsigned OFF_W      = $clog2(MAX_OFF + 1);
  localparam int unsigned CNT_W      = (OFF_W > BLANK_W) ? OFF_W : BLANK_W;

  chop_state_e      state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val, off_len_m1;

  // Named internal events
  logic trig_w, off_done_w, blank_done_w, rearm_w, blank_zero_w;

  assign trig_w       = (state_q == ST_ARMED) && oc_i;
  assign off_done_w   = (state_q == ST_OFF)   && tmr_zero;
  assign blank_done_w = (state_q == ST_BLANK) && tmr_zero;
  assign rearm_w      = blank_done_w && oc_i;
  assign blank_zero_w = (blank_len_i == '0);

  chop_offtime_sel #(.CNT_W(CNT_W), .CYC_PER_US(CYC_PER_US)) sel_i (
    .sel_i   (toff_sel_i),
    .len_m1_o(off_len_m1)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = off_len_m1;
    case (state_q)
      ST_ARMED: if (trig_w) begin
        state_d  = ST_OFF;
        tmr_load = 1'b1;
      end
      ST_OFF: if (off_done_w) begin
        if (blank_zero_w) begin
          state_d = ST_ARMED;
        end else begin
          state_d  = ST_BLANK;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(blank_len_i) - CNT_W'(1);
        end
      end
      ST_BLANK: if (blank_done_w) begin
        if (rearm_w) begin
          state_d  = ST_OFF;
          tmr_load = 1'b1;
        end else begin
          state_d = ST_ARMED;
        end
      end
      default: state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  chop_down_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  assign pwm_o = (state_q != ST_OFF);

  chop_pattern_gate #(.NPH(NPH)) gate_i (
    .pwm_i(pwm_o),
    .pat_i(pat_i),
    .pat_o(pat_o)
  );

  AST_LOW_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_w |=> !pwm_o); // R2
  AST_FALL_NEEDS_OC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_o) |-> $past(oc_i)); // R5
  AST_BLANK_PWM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BLANK) |-> pwm_o); // R6
  AST_GATE_OFF_WHEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_o |-> (pat_o == '0)); // R9

endmodule

// File: tb/chop_const_toff_tb_top.sv
`timescale 1ns/1ps
module chop_const_toff_tb_top;
  localparam int unsigned BW  = 8;
  localparam int unsigned NPH = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           oc = 1'b0;
  logic [1:0]     sel = 2'd0;
  logic [BW-1:0]  blank = '0;
  logic [NPH-1:0] pat = '0;
  logic           pwm;
  logic [NPH-1:0] pat_g;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  chop_const_toff #(.CLK_HZ(1_000_000), .BLANK_W(BW), .NPH(NPH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .oc_i(oc), .toff_sel_i(sel),
    .blank_len_i(blank), .pat_i(pat), .pwm_o(pwm), .pat_o(pat_g)
  );

  // Expected off length in cycles at 1 cycle per microsecond (R3 table).
  function automatic int exp_off(input int s);
    int us_tab [4] = '{30, 20, 45, 70};
    return us_tab[s];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic lvl, input int cap, output int n);
    n = 0;
    while (pwm === lvl && n < cap) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int lo, hi, lo2, n;
    repeat (3) @(negedge clk);
    chk("R1 pwm after reset", int'(pwm), 1);
    pat = 3'b101;
    #1 chk("R1 pattern passes after reset", int'(pat_g), 5);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pwm idle after release", int'(pwm), 1);

    // R2 R3 R7 sweep: oc held high across select codes and blanking lengths
    for (int s = 0; s < 4; s++) begin
      for (int bi = 0; bi < 4; bi++) begin
        int b;
        b = (bi == 0) ? 0 : (1 << bi) - 1;
        sel = 2'(s); blank = BW'(b); oc = 1'b1;
        @(negedge clk);
        run_len(1'b0, 500, lo);
        run_len(1'b1, 500, hi);
        oc = 1'b0;
        run_len(1'b0, 500, lo2);
        chk($sformatf("R2 R3 off len sel=%0d b=%0d", s, b), lo, exp_off(s));
        chk($sformatf("R7 gap sel=%0d b=%0d", s, b), hi, (b > 1) ? b : 1);
        chk($sformatf("R7 retrigger len sel=%0d b=%0d", s, b), lo2, exp_off(s));
        repeat (b + 3) @(negedge clk);
      end
    end

    // R4: select changed mid-interval
    blank = '0; sel = 2'd1; oc = 1'b1;
    @(negedge clk);
    oc = 1'b0; sel = 2'd3;
    run_len(1'b0, 500, lo);
    chk("R4 select captured at start", lo, 20);
    repeat (3) @(negedge clk);

    // R5: oc pulse inside off interval
    sel = 2'd0; oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    n = 0;
    while (pwm === 1'b0 && n < 500) begin
      n++;
      oc = (n == 6);
      @(negedge clk);
    end
    oc = 1'b0;
    chk("R5 off not extended", n, 30);
    run_len(1'b1, 50, hi);
    chk("R5 no restart after pulse", hi, 50);

    // R6: pulse during blanking is ignored
    blank = 8'd7; sel = 2'd1; oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    run_len(1'b0, 500, lo);
    chk("R6 off len before blank", lo, 20);
    oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    run_len(1'b1, 40, hi);
    chk("R6 blank pulse ignored", hi, 40);

    // R8: no overcurrent, pwm stays high
    run_len(1'b1, 100, hi);
    chk("R8 stays high", hi, 100);

    // R9: gating, all patterns with pwm high then low
    for (int p = 0; p < 8; p++) begin
      pat = 3'(p);
      #1 chk($sformatf("R9 pass p=%0d", p), int'(pat_g), p);
    end
    blank = '0; sel = 2'd3; oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    for (int p = 0; p < 8; p++) begin
      pat = 3'(p);
      #1 chk($sformatf("R9 block p=%0d", p), int'(pat_g), 0);
    end
    run_len(1'b0, 500, lo);
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        summary();
        $finish;
      end
    end
  end

endmodule